// File: doc/BRIEF.md
# Serial-Bus Link Node-Address Filter

This block holds the node identity and the transmit acknowledge status of a serial-bus link layer in one 32-bit register. It also decides whether each incoming packet is addressed to this node. The host reads the register and writes to it. After every bus reset, the physical layer reports a status word, and the block takes this node's physical ID and root flag from it. The transmit side reports the outcome of each asynchronous packet: a normal ack code, an ack timeout or an ack error.

The block drives a 16-bit source address, which is the bus number followed by the node number, for outgoing packets. It also drives a combinational accept flag for the destination address presented with each incoming packet. A destination is accepted when both its bus field and its node field either match this node's values or hold the all-ones broadcast value.

Top module: `nafilt_top`

## Requirements
- R1: After reset, host_rdata reads FFFF_0000h and src_addr reads FFFFh.
- R2: A host write (host_wr=1) loads host_wdata[31:22] into the bus number and host_wdata[21:16] into the node number, and the new values appear on host_rdata and src_addr={bus,node} in the next cycle.
- R3: Bit 15 of host_rdata is the root flag and cannot be changed by a host write. Bits [14:9] and [3:0] always read zero, whatever the host writes.
- R4: When phy_stat_vld=1, the node number takes phy_id and the root flag takes phy_root in the next cycle. If a host write to the node number happens in the same cycle, the physical-layer value wins.
- R5: When ack_vld=1 and neither ack_timeout nor ack_error is set, the 5-bit ack field host_rdata[8:4] takes {1'b0, ack_code}.
- R6: ack_timeout=1 stores 10000b in the ack field. Otherwise, ack_error=1 stores 10011b. The priority order is timeout, then error, then normal code.
- R7: A host write changes the ack field to host_wdata[8:4] only while diag_rw_en=1, and only when no transmit ack event occurs in the same cycle. Otherwise the ack field keeps its value.
- R8: dst_accept is 1 exactly when dst_vld=1 and both of these hold: dst_addr[15:6] equals the bus number or 3FFh, and dst_addr[5:0] equals the node number or 3Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read value |
| diag_rw_en | input | 1 | Diagnostic enable for host writes to the ack field |
| phy_stat_vld | input | 1 | Physical-layer status transfer strobe |
| phy_id | input | 6 | Reported physical ID |
| phy_root | input | 1 | Reported root flag |
| ack_vld | input | 1 | Normal ack received |
| ack_code | input | 4 | Received ack code |
| ack_timeout | input | 1 | Ack timeout event |
| ack_error | input | 1 | Ack packet error event |
| src_addr | output | 16 | Source address for outgoing packets |
| dst_vld | input | 1 | Destination address valid |
| dst_addr | input | 16 | Incoming packet destination address |
| dst_accept | output | 1 | Destination accepted |

## Verification
The bench uses the default widths: a 10-bit bus field and a 6-bit node field, with broadcast values 3FFh and 3Fh. These widths are small enough that the random destinations can be biased toward four cases: an exact match, a broadcast bus, a broadcast node, and a value that differs from this node's address in a single bit. Random cycles overlap physical-layer updates, host writes, diagnostic enables and ack events, so every priority collision between these sources occurs many times.

// File: rtl/nafilt_pkg.sv
package nafilt_pkg;
    localparam int BUS_W   = 10;
    localparam int NODE_W  = 6;
    localparam int CODE_W  = 4;
    localparam int ACK_W   = CODE_W + 1;
    localparam int REG_W   = 32;
    localparam int BUS_LSB  = REG_W - BUS_W;
    localparam int NODE_LSB = BUS_LSB - NODE_W;
    localparam int ROOT_BIT = NODE_LSB - 1;
    localparam int ACK_LSB  = 4;
    localparam logic [ACK_W-1:0] ACK_TIMEOUT_CODE = 5'b10000;
    localparam logic [ACK_W-1:0] ACK_ERROR_CODE   = 5'b10011;

    typedef struct packed {
        logic [BUS_W-1:0]  bus;
        logic [NODE_W-1:0] node;
        logic              root;
        logic [ACK_W-1:0]  ack;
    } nafilt_state_t;
endpackage

// File: rtl/nafilt_regs.sv
module nafilt_regs
    import nafilt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [REG_W-1:0]     host_wdata,
    input  logic                 diag_rw_en,
    input  logic                 phy_stat_vld,
    input  logic [NODE_W-1:0]    phy_id,
    input  logic                 phy_root,
    input  logic                 ack_vld,
    input  logic [CODE_W-1:0]    ack_code,
    input  logic                 ack_timeout,
    input  logic                 ack_error,
    output nafilt_state_t        state_o
);
    nafilt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (host_wr) begin
            state_d.bus  = host_wdata[BUS_LSB +: BUS_W];
            state_d.node = host_wdata[NODE_LSB +: NODE_W];
            if (diag_rw_en) begin
                state_d.ack = host_wdata[ACK_LSB +: ACK_W];
            end
        end
        if (phy_stat_vld) begin
            state_d.node = phy_id;
            state_d.root = phy_root;
        end
        if (ack_timeout) begin
            state_d.ack = ACK_TIMEOUT_CODE;
        end else if (ack_error) begin
            state_d.ack = ACK_ERROR_CODE;
        end else if (ack_vld) begin
            state_d.ack = {1'b0, ack_code};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.bus  <= '1;
            state_q.node <= '1;
            state_q.root <= 1'b0;
            state_q.ack  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/nafilt_match.sv
module nafilt_match #(
    parameter int BUS_W  = 10,
    parameter int NODE_W = 6,
    localparam int ADDR_W = BUS_W + NODE_W
) (
    input  logic [BUS_W-1:0]  my_bus,
    input  logic [NODE_W-1:0] my_node,
    input  logic              dst_vld,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic              accept
);
    logic [BUS_W-1:0]  dst_bus;
    logic [NODE_W-1:0] dst_node;
    logic              bus_ok, node_ok;

    always_comb begin
        dst_bus  = dst_addr[ADDR_W-1 -: BUS_W];
        dst_node = dst_addr[NODE_W-1:0];
        bus_ok   = (dst_bus == my_bus) || (&dst_bus);
        node_ok  = (dst_node == my_node) || (&dst_node);
        accept   = dst_vld && bus_ok && node_ok;
    end
endmodule

// File: rtl/nafilt_top.sv
module nafilt_top
    import nafilt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        diag_rw_en,
    input  logic        phy_stat_vld,
    input  logic [5:0]  phy_id,
    input  logic        phy_root,
    input  logic        ack_vld,
    input  logic [3:0]  ack_code,
    input  logic        ack_timeout,
    input  logic        ack_error,
    output logic [15:0] src_addr,
    input  logic        dst_vld,
    input  logic [15:0] dst_addr,
    output logic        dst_accept
);
    nafilt_state_t st;

    nafilt_regs i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .diag_rw_en   (diag_rw_en),
        .phy_stat_vld (phy_stat_vld),
        .phy_id       (phy_id),
        .phy_root     (phy_root),
        .ack_vld      (ack_vld),
        .ack_code     (ack_code),
        .ack_timeout  (ack_timeout),
        .ack_error    (ack_error),
        .state_o      (st)
    );

    nafilt_match #(.BUS_W(BUS_W), .NODE_W(NODE_W)) i_match (
        .my_bus   (st.bus),
        .my_node  (st.node),
        .dst_vld  (dst_vld),
        .dst_addr (dst_addr),
        .accept   (dst_accept)
    );

    always_comb begin
        host_rdata = '0;
        host_rdata[BUS_LSB +: BUS_W]   = st.bus;
        host_rdata[NODE_LSB +: NODE_W] = st.node;
        host_rdata[ROOT_BIT]           = st.root;
        host_rdata[ACK_LSB +: ACK_W]   = st.ack;
        src_addr = {st.bus, st.node};
    end
endmodule

// File: rtl/nafilt_chk.sv
module nafilt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        diag_rw_en,
    input logic [31:0] host_rdata,
    input logic        phy_stat_vld,
    input logic [5:0]  phy_id,
    input logic        phy_root,
    input logic        ack_vld,
    input logic        ack_timeout,
    input logic        ack_error,
    input logic [15:0] src_addr,
    input logic        dst_vld,
    input logic        dst_accept
);
    AST_PHY_NODE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        phy_stat_vld |=> host_rdata[21:16] == $past(phy_id)); // R4
    AST_PHY_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
        phy_stat_vld |=> host_rdata[15] == $past(phy_root)); // R4
    AST_ROOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_stat_vld |=> $stable(host_rdata[15])); // R3
    AST_ACK_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_timeout |=> host_rdata[8:4] == 5'b10000); // R6
    AST_ACK_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_error && !ack_timeout) |=> host_rdata[8:4] == 5'b10011); // R6
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_vld && !ack_timeout && !ack_error && !(host_wr && diag_rw_en))
        |=> $stable(host_rdata[8:4])); // R7
    AST_SRC_TRACKS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        src_addr == host_rdata[31:16]); // R2
    AST_ACCEPT_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        dst_accept |-> dst_vld); // R8
endmodule

bind nafilt_top nafilt_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .diag_rw_en   (diag_rw_en),
    .host_rdata   (host_rdata),
    .phy_stat_vld (phy_stat_vld),
    .phy_id       (phy_id),
    .phy_root     (phy_root),
    .ack_vld      (ack_vld),
    .ack_timeout  (ack_timeout),
    .ack_error    (ack_error),
    .src_addr     (src_addr),
    .dst_vld      (dst_vld),
    .dst_accept   (dst_accept)
);

// File: tb/test_nafilt_top.sv
`timescale 1ns/1ps
module test_nafilt_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        diag_rw_en;
    logic        phy_stat_vld;
    logic [5:0]  phy_id;
    logic        phy_root;
    logic        ack_vld;
    logic [3:0]  ack_code;
    logic        ack_timeout;
    logic        ack_error;
    logic [15:0] src_addr;
    logic        dst_vld;
    logic [15:0] dst_addr;
    logic        dst_accept;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [9:0] m_bus;
    logic [5:0] m_node;
    logic       m_root;
    logic [4:0] m_ack;

    always #4 clk = ~clk;

    nafilt_top i_nafilt_top (.*);

    function automatic logic [31:0] exp_rdata();
        return {m_bus, m_node, m_root, 6'b0, m_ack, 4'b0};
    endfunction

    function automatic logic exp_accept(logic v, logic [15:0] a);
        return v && ((a[15:6] == m_bus) || (a[15:6] == 10'h3FF))
                 && ((a[5:0] == m_node) || (a[5:0] == 6'h3F));
    endfunction

    task automatic model_step();
        if (host_wr) begin
            m_bus  = host_wdata[31:22];
            m_node = host_wdata[21:16];
            if (diag_rw_en) m_ack = host_wdata[8:4];
        end
        if (phy_stat_vld) begin
            m_node = phy_id;
            m_root = phy_root;
        end
        if (ack_timeout)      m_ack = 5'b10000;
        else if (ack_error)   m_ack = 5'b10011;
        else if (ack_vld)     m_ack = {1'b0, ack_code};
    endtask

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_wr = 0; host_wdata = '0; diag_rw_en = 0;
        phy_stat_vld = 0; phy_id = '0; phy_root = 0;
        ack_vld = 0; ack_code = '0; ack_timeout = 0; ack_error = 0;
    endtask

    // one clock: inputs already driven at negedge; update model, check at next negedge
    task automatic step(string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check32(req, host_rdata, exp_rdata());
        check32(req, {16'h0, src_addr}, {16'h0, m_bus, m_node});
        idle();
    endtask

    task automatic chk_dst(string req, logic v, logic [15:0] a);
        dst_vld = v; dst_addr = a;
        #1;
        check32(req, {31'h0, dst_accept}, {31'h0, exp_accept(v, a)});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(1394);
        idle();
        dst_vld = 0; dst_addr = '0;
        rst_n = 0;
        m_bus = 10'h3FF; m_node = 6'h3F; m_root = 0; m_ack = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset value
        check32("R1", host_rdata, 32'hFFFF_0000);
        check32("R1", {16'h0, src_addr}, 32'h0000_FFFF);
        // R8 broadcast / vld low after reset
        chk_dst("R8", 1, 16'hFFFF);
        chk_dst("R8", 0, 16'hFFFF);
        // R2 write bus and node; R3 root and reserved bits ignore writes
        host_wr = 1; host_wdata = 32'h1234_FFFF;
        step("R2_R3");
        check32("R3", {31'h0, host_rdata[15]}, 32'h0);
        // R8 exact, bus-broadcast, node-broadcast, mismatch
        chk_dst("R8", 1, {m_bus, m_node});
        chk_dst("R8", 1, {10'h3FF, m_node});
        chk_dst("R8", 1, {m_bus, 6'h3F});
        chk_dst("R8", 1, {m_bus ^ 10'h001, m_node});
        chk_dst("R8", 1, {m_bus, m_node ^ 6'h01});
        // R4 PHY wins over host node write
        host_wr = 1; host_wdata = 32'hABCD_0000;
        phy_stat_vld = 1; phy_id = 6'h05; phy_root = 1;
        step("R4");
        check32("R4", {26'h0, host_rdata[21:16]}, 32'h5);
        // R5 normal ack
        ack_vld = 1; ack_code = 4'hD;
        step("R5");
        // R6 timeout beats error beats normal
        ack_vld = 1; ack_code = 4'h1; ack_timeout = 1; ack_error = 1;
        step("R6");
        ack_vld = 1; ack_code = 4'h2; ack_error = 1;
        step("R6");
        // R7 ack write without diag ignored, with diag takes effect, loses to event
        host_wr = 1; host_wdata = 32'h0000_0150;
        step("R7");
        host_wr = 1; host_wdata = 32'h0000_0150; diag_rw_en = 1;
        step("R7");
        host_wr = 1; host_wdata = 32'h0000_01F0; diag_rw_en = 1; ack_vld = 1; ack_code = 4'h4;
        step("R7");
        // random mix
        for (int i = 0; i < 600; i++) begin
            r = $urandom();
            host_wr      = (r[2:0] == 0);
            host_wdata   = $urandom();
            diag_rw_en   = r[3];
            phy_stat_vld = (r[6:4] == 0);
            phy_id       = r[12:7];
            phy_root     = r[13];
            ack_vld      = r[14];
            ack_code     = r[18:15];
            ack_timeout  = (r[21:19] == 0);
            ack_error    = (r[24:22] == 0);
            step("R2_R4_R5_R6_R7");
            r = $urandom();
            case (r[1:0])
                2'd0: chk_dst("R8", r[2], {m_bus, m_node});
                2'd1: chk_dst("R8", r[2], {10'h3FF, r[8:3]});
                2'd2: chk_dst("R8", r[2], {r[12:3], 6'h3F});
                default: chk_dst("R8", r[2], {m_bus, m_node} ^ (16'h1 << r[6:3]));
            endcase
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule